// File: doc/BRIEF.md
# DRAM Refresh Sequencer with Multiplexed Row/Column Addressing

This block sits between a single requester and a dynamic memory array of 2048 rows by 2048 columns, where each location holds a 4-bit value. The requester presents a flat 22-bit word address with a valid/ready handshake. The block splits that address into a row half and a column half. Both halves go out on one shared 11-bit address bus: the row goes first under a row strobe, then the column under a column strobe.

Stored charge leaks away, so the block also keeps every row alive on its own. A programmable interval timer raises a refresh request. An internal row counter then selects the next row. The row is opened, which reads it into the array's sense stage, and is then restored, which writes the same data back. The requester is held off for the whole refresh. A refresh that falls due during an access waits for that access to end. It then wins against any request that is waiting.

Top module: `dram_rfsh_ctrl`

## Requirements
- R1: The row is `req_addr[21:11]` and the column is `req_addr[10:0]`. `mem_addr` carries the row during the row phase and the column during the column phase.
- R2: If a request is accepted at the clock edge that ends cycle t, cycle t+1 is the row phase (`mem_row_stb`=1, `mem_col_stb`=0). Cycle t+2 is the column phase (both strobes 1). In cycle t+3, `rsp_valid` is 1 for exactly one cycle. For a read, `rsp_rdata` then holds the `mem_rdata` value present during the column phase.
- R3: `req_ready` is 0 from cycle t+1 through cycle t+3. It is 1 again in cycle t+4 when no refresh is due.
- R4: In the column phase, `mem_we` equals the request's write flag, and `mem_wdata` carries the write data.
- R5: With `refresh_interval` = N > 0, a refresh becomes due every N cycles. An idle block therefore refreshes exactly N cycles apart. N = 0 disables refresh.
- R6: A refresh takes two cycles on the same `mem_addr`. The first is the open phase (`mem_row_stb`=1, `mem_we`=0, `mem_col_stb`=0). The second is the restore phase (`mem_row_stb`=1, `mem_we`=1, `mem_col_stb`=0).
- R7: Successive refreshes address rows 0, 1, 2, and so on, and the row counter wraps from 2047 back to 0.
- R8: A refresh that falls due during an access starts once that access ends, ahead of any waiting request. Under continuous traffic, refreshes are therefore never more than N+4 cycles apart.
- R9: `req_ready` is 0 throughout a refresh, and also while a refresh is due but has not yet started.
- R10: Reset puts the block in idle. `req_ready` is 1, all strobes and `rsp_valid` are 0, and the first refresh after reset uses row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_interval | input | 16 | Cycles between refresh requests; 0 disables refresh |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Flat word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | Access complete (read data valid) |
| rsp_rdata | output | 4 | Read data |
| mem_addr | output | 11 | Multiplexed row/column address bus |
| mem_row_stb | output | 1 | Row strobe |
| mem_col_stb | output | 1 | Column strobe |
| mem_we | output | 1 | Array write enable |
| mem_wdata | output | 4 | Data toward the array |
| mem_rdata | input | 4 | Data from the array |

## Verification
The access path is exercised with corner addresses whose row and column halves are all zeros or all ones, or where exactly one half is non-zero. These show whether the two halves are swapped or wrongly sliced. Seeded random reads and writes are then checked against a bench shadow store, which catches data-path and timing slips. Refresh is tried in four settings:
- idle, with the interval disabled, which isolates the timer enable;
- idle, with a fixed interval, which checks the exact spacing;
- under back-to-back requests, which separates correct priority from refresh starvation;
- over more than 2048 refreshes, which exposes a wrong row-counter wrap.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_COL,
      ST_DONE,
      ST_RF_OPEN,
      ST_RF_RESTORE
   } seq_state_t;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_REQ_ROW,
      SEL_REQ_COL,
      SEL_REFRESH
   } addr_sel_t;
endpackage

// File: rtl/dram_rfsh_timer.sv
module dram_rfsh_timer #(
   parameter int INT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INT_W-1:0] interval,
   input  logic             take,
   output logic             pending
);
   if (INT_W < 2) begin : g_bad_width
      $error("dram_rfsh_timer: INT_W must be at least 2");
   end

   logic [INT_W-1:0] cnt_q;
   logic             pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         if (take) pend_q <= 1'b0;
         if (interval == '0) begin
            cnt_q <= '0;
         end else if (cnt_q >= interval - INT_W'(1)) begin
            cnt_q  <= '0;
            pend_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + INT_W'(1);
         end
      end
   end

   assign pending = pend_q;

   // R8
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !take) |=> pend_q);
   // R5
   pend_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (interval == '0 && !pend_q) |=> !pend_q);
endmodule

// File: rtl/dram_rfsh_rowctr.sv
module dram_rfsh_rowctr #(
   parameter int ROW_W    = 11,
   parameter int NUM_ROWS = 2048
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [ROW_W-1:0] row
);
   localparam logic [ROW_W-1:0] LAST = ROW_W'(NUM_ROWS - 1);

   if (NUM_ROWS < 2 || NUM_ROWS > (1 << ROW_W)) begin : g_bad_rows
      $error("dram_rfsh_rowctr: NUM_ROWS out of range for ROW_W");
   end

   logic [ROW_W-1:0] row_q;

   if (NUM_ROWS == (1 << ROW_W)) begin : g_natural_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)   row_q <= '0;
         else if (adv) row_q <= row_q + ROW_W'(1);
      end
   end else begin : g_compare_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)   row_q <= '0;
         else if (adv) row_q <= (row_q == LAST) ? '0 : row_q + ROW_W'(1);
      end
   end

   assign row = row_q;

   // R7
   row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && row_q == LAST) |=> row_q == '0);
   // R7
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && row_q != LAST) |=> row_q == $past(row_q) + ROW_W'(1));
   // R7
   row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(row_q));
endmodule

// File: rtl/dram_rfsh_amux.sv
module dram_rfsh_amux
   import dram_rfsh_pkg::*;
#(
   parameter int ROW_W  = 11,
   parameter int COL_W  = 11,
   parameter int BUS_W  = 11,
   parameter bit ROW_HI = 1'b1
) (
   input  logic [ROW_W+COL_W-1:0] flat_addr,
   input  logic [ROW_W-1:0]       ref_row,
   input  addr_sel_t              sel,
   output logic [BUS_W-1:0]       bus
);
   if (BUS_W < ROW_W || BUS_W < COL_W) begin : g_bad_bus
      $error("dram_rfsh_amux: BUS_W narrower than a half address");
   end

   logic [ROW_W-1:0] req_row;
   logic [COL_W-1:0] req_col;

   if (ROW_HI) begin : g_row_upper
      assign req_row = flat_addr[ROW_W+COL_W-1:COL_W];
      assign req_col = flat_addr[COL_W-1:0];
   end else begin : g_row_lower
      assign req_row = flat_addr[ROW_W-1:0];
      assign req_col = flat_addr[ROW_W+COL_W-1:ROW_W];
   end

   always_comb begin
      unique case (sel)
         SEL_REQ_ROW: bus = BUS_W'(req_row);
         SEL_REQ_COL: bus = BUS_W'(req_col);
         SEL_REFRESH: bus = BUS_W'(ref_row);
         default:     bus = '0;
      endcase
   end
endmodule

// File: rtl/dram_rfsh_ctrl.sv
module dram_rfsh_ctrl
   import dram_rfsh_pkg::*;
#(
   parameter int ROW_W    = 11,
   parameter int COL_W    = 11,
   parameter int DATA_W   = 4,
   parameter int INT_W    = 16,
   parameter int NUM_ROWS = 2048,
   parameter bit ROW_HI   = 1'b1,
   localparam int ADDR_W  = ROW_W + COL_W,
   localparam int BUS_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INT_W-1:0]  refresh_interval,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [BUS_W-1:0]  mem_addr,
   output logic              mem_row_stb,
   output logic              mem_col_stb,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_params
      $error("dram_rfsh_ctrl: widths must be positive");
   end

   seq_state_t        state_q, state_d;
   logic              ref_pend, ref_take, row_adv, accept;
   logic [ROW_W-1:0]  ref_row;
   logic [ADDR_W-1:0] lat_addr;
   logic              lat_we;
   logic [DATA_W-1:0] lat_wdata, rdata_q;
   addr_sel_t         asel;

   dram_rfsh_timer #(.INT_W(INT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .interval(refresh_interval),
      .take(ref_take), .pending(ref_pend)
   );

   dram_rfsh_rowctr #(.ROW_W(ROW_W), .NUM_ROWS(NUM_ROWS)) u_rowctr (
      .clk(clk), .rst_n(rst_n), .adv(row_adv), .row(ref_row)
   );

   dram_rfsh_amux #(.ROW_W(ROW_W), .COL_W(COL_W), .BUS_W(BUS_W), .ROW_HI(ROW_HI)) u_amux (
      .flat_addr(lat_addr), .ref_row(ref_row), .sel(asel), .bus(mem_addr)
   );

   assign req_ready = (state_q == ST_IDLE) && !ref_pend;
   assign accept    = req_valid && req_ready;
   assign ref_take  = (state_q == ST_IDLE) && ref_pend;
   assign row_adv   = (state_q == ST_RF_RESTORE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (ref_pend)       state_d = ST_RF_OPEN;
            else if (req_valid) state_d = ST_ROW;
         end
         ST_ROW:        state_d = ST_COL;
         ST_COL:        state_d = ST_DONE;
         ST_DONE:       state_d = ST_IDLE;
         ST_RF_OPEN:    state_d = ST_RF_RESTORE;
         ST_RF_RESTORE: state_d = ST_IDLE;
         default:       state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         lat_addr  <= '0;
         lat_we    <= 1'b0;
         lat_wdata <= '0;
         rdata_q   <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            lat_addr  <= req_addr;
            lat_we    <= req_we;
            lat_wdata <= req_wdata;
         end
         if (state_q == ST_COL && !lat_we) rdata_q <= mem_rdata;
      end
   end

   always_comb begin
      unique case (state_q)
         ST_ROW:                    asel = SEL_REQ_ROW;
         ST_COL:                    asel = SEL_REQ_COL;
         ST_RF_OPEN, ST_RF_RESTORE: asel = SEL_REFRESH;
         default:                   asel = SEL_NONE;
      endcase
   end

   assign mem_row_stb = state_q inside {ST_ROW, ST_COL, ST_RF_OPEN, ST_RF_RESTORE};
   assign mem_col_stb = (state_q == ST_COL);
   assign mem_we      = (state_q == ST_COL && lat_we) || (state_q == ST_RF_RESTORE);
   assign mem_wdata   = lat_wdata;
   assign rsp_valid   = (state_q == ST_DONE);
   assign rsp_rdata   = rdata_q;

   // R9
   ready_in_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_row_stb && !mem_col_stb && $past(mem_row_stb) && !$past(mem_col_stb)) |-> !req_ready);
   // R2
   col_after_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_col_stb) |-> $past(mem_row_stb) && mem_row_stb);
   // R2
   rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R3
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready ##1 !req_ready ##1 (!req_ready && rsp_valid));
   // R6
   restore_after_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !mem_col_stb) |-> mem_row_stb && $past(mem_row_stb) && !$past(mem_we) && $stable(mem_addr));
endmodule

// File: tb/dram_rfsh_ctrl_test.sv
`timescale 1ns/1ps
module dram_rfsh_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] refresh_interval = '0;
   logic        req_valid = 1'b0, req_we = 1'b0;
   logic [21:0] req_addr = '0;
   logic [3:0]  req_wdata = '0;
   logic        req_ready, rsp_valid, mem_row_stb, mem_col_stb, mem_we;
   logic [3:0]  rsp_rdata, mem_wdata;
   logic [3:0]  mem_rdata = '0;
   logic [10:0] mem_addr;

   always #2 clk = ~clk;

   dram_rfsh_ctrl uut (
      .clk(clk), .rst_n(rst_n), .refresh_interval(refresh_interval),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_row_stb(mem_row_stb), .mem_col_stb(mem_col_stb),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // behavioural array driven only from the pins
   logic [3:0]  model_mem [int unsigned];
   logic [3:0]  shadow    [int unsigned];
   logic [10:0] open_row = '0;

   always @(posedge clk) begin
      if (mem_row_stb && !mem_col_stb && !mem_we) open_row <= mem_addr;
      if (mem_col_stb && mem_we) model_mem[{10'd0, open_row, mem_addr}] = mem_wdata;
   end
   always @(negedge clk) begin
      if (mem_col_stb)
         mem_rdata <= model_mem.exists({10'd0, open_row, mem_addr}) ?
                      model_mem[{10'd0, open_row, mem_addr}] : 4'h0;
   end

   int n_chk = 0, n_bad = 0;
   int phase_id = 0;
   bit spacing_on = 0, bound_on = 0;

   function automatic logic [10:0] exp_row(input logic [21:0] a); return a[21:11]; endfunction
   function automatic logic [10:0] exp_col(input logic [21:0] a); return a[10:0]; endfunction
   function automatic logic [3:0] exp_read(input logic [21:0] a);
      return shadow.exists({10'd0, a}) ? shadow[{10'd0, a}] : 4'h0;
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // refresh monitor with its own counters
   int mon_chk = 0, mon_bad = 0, n_restore = 0, wrap_seen = 0;
   int cyc = 0, last_cyc = 0, last_phase = -1;
   int exp_ref = 0;
   bit p_row = 0, p_col = 0, p_we = 0;
   logic [10:0] p_addr = '0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n && mem_row_stb && mem_we && !mem_col_stb) begin
         mon_chk++;
         if (int'(mem_addr) != exp_ref) begin
            mon_bad++;
            $display("FAIL %s refresh row: actual=%0h expected=%0h",
                     (n_restore == 0) ? "R10" : "R7", mem_addr, exp_ref);
         end
         mon_chk++;
         if (!(p_row && !p_col && !p_we && p_addr == mem_addr)) begin
            mon_bad++;
            $display("FAIL R6 open phase before restore: actual=%0h expected=%0h", p_addr, mem_addr);
         end
         mon_chk++;
         if (req_ready) begin
            mon_bad++;
            $display("FAIL R9 ready during refresh: actual=1 expected=0");
         end
         if (mem_addr == 11'd0 && n_restore > 0) wrap_seen++;
         if (last_phase == phase_id && n_restore > 0) begin
            if (spacing_on) begin
               mon_chk++;
               if (cyc - last_cyc != int'(refresh_interval)) begin
                  mon_bad++;
                  $display("FAIL R5 refresh spacing: actual=%0d expected=%0d", cyc - last_cyc, refresh_interval);
               end
            end
            if (bound_on) begin
               mon_chk++;
               if (cyc - last_cyc > int'(refresh_interval) + 4) begin
                  mon_bad++;
                  $display("FAIL R8 refresh starved: actual=%0d expected<=%0d", cyc - last_cyc, refresh_interval + 4);
               end
            end
         end
         last_cyc   = cyc;
         last_phase = phase_id;
         exp_ref    = (exp_ref + 1) % 2048;
         n_restore++;
      end
      p_row  = mem_row_stb;
      p_col  = mem_col_stb;
      p_we   = mem_we;
      p_addr = mem_addr;
   end

   task automatic do_req(input bit we, input logic [21:0] a, input logic [3:0] d, input bit strict);
      @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);  // row phase, t+1
      req_valid = 1'b0;
      chk(mem_row_stb && !mem_col_stb, "R2", "row phase strobes", {mem_row_stb, mem_col_stb}, 2'b10);
      chk(mem_addr == exp_row(a), "R1", "row on bus", mem_addr, exp_row(a));
      chk(!req_ready, "R3", "ready in row phase", req_ready, 0);
      @(negedge clk);  // column phase, t+2
      chk(mem_row_stb && mem_col_stb, "R2", "column phase strobes", {mem_row_stb, mem_col_stb}, 2'b11);
      chk(mem_addr == exp_col(a), "R1", "column on bus", mem_addr, exp_col(a));
      chk(mem_we == we, "R4", "write enable", mem_we, we);
      if (we) chk(mem_wdata == d, "R4", "write data", mem_wdata, d);
      @(negedge clk);  // completion, t+3
      chk(rsp_valid, "R2", "response valid", rsp_valid, 1);
      chk(!req_ready, "R3", "ready at completion", req_ready, 0);
      if (!we) chk(rsp_rdata == exp_read(a), "R2", "read data", rsp_rdata, exp_read(a));
      else shadow[{10'd0, a}] = d;
      if (strict) begin
         @(negedge clk);
         chk(req_ready, "R3", "ready after completion", req_ready, 1);
         chk(!rsp_valid, "R2", "response single cycle", rsp_valid, 0);
      end
   endtask

   task automatic main_seq();
      int base;
      void'($urandom(32'd20240611));
      // reset
      repeat (4) @(negedge clk);
      chk(req_ready, "R10", "ready in reset", req_ready, 1);
      chk(!mem_row_stb && !mem_col_stb && !rsp_valid, "R10", "strobes in reset",
          {mem_row_stb, mem_col_stb, rsp_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R10", "ready after reset", req_ready, 1);

      // directed corner addresses, refresh disabled
      do_req(1'b1, 22'h3FFFFF, 4'hA, 1'b1);
      do_req(1'b1, 22'h000000, 4'h5, 1'b1);
      do_req(1'b1, 22'h000800, 4'h3, 1'b1);
      do_req(1'b1, 22'h0007FF, 4'hC, 1'b1);
      do_req(1'b0, 22'h3FFFFF, 4'h0, 1'b1);
      do_req(1'b0, 22'h000000, 4'h0, 1'b1);
      do_req(1'b0, 22'h000800, 4'h0, 1'b1);
      do_req(1'b0, 22'h0007FF, 4'h0, 1'b1);
      do_req(1'b0, 22'h155555, 4'h0, 1'b1);
      base = n_restore;
      repeat (200) @(negedge clk);
      chk(n_restore == base, "R5", "no refresh when interval is 0", n_restore - base, 0);

      // idle refresh with exact spacing
      phase_id++; spacing_on = 1; refresh_interval = 16'd10;
      base = n_restore;
      repeat (300) @(negedge clk);
      chk(n_restore - base >= 28, "R5", "idle refresh count", n_restore - base, 29);
      spacing_on = 0;

      // back-to-back traffic: refresh must not starve
      phase_id++; bound_on = 1; refresh_interval = 16'd12;
      base = n_restore;
      for (int i = 0; i < 150; i++)
         do_req(1'($urandom_range(0, 1)), 22'($urandom), 4'($urandom), 1'b0);
      chk(n_restore - base >= 40, "R8", "refreshes under traffic", n_restore - base, 50);
      bound_on = 0;

      // random mix with gaps
      phase_id++; refresh_interval = 16'd25;
      for (int i = 0; i < 300; i++) begin
         logic [21:0] a;
         case ($urandom_range(0, 5))
            0:       a = 22'h3FFFFF;
            1:       a = 22'h000000;
            2:       a = {11'($urandom), 11'h7FF};
            default: a = 22'($urandom_range(0, 63)) | (22'($urandom_range(0, 3)) << 11);
         endcase
         do_req(1'($urandom_range(0, 1)), a, 4'($urandom), 1'b0);
         repeat ($urandom_range(0, 3)) @(negedge clk);
      end

      // long idle run to pass the counter wrap
      phase_id++; refresh_interval = 16'd3;
      repeat (7000) @(negedge clk);
      chk(wrap_seen >= 1, "R7", "row counter wrapped to 0", wrap_seen, 1);
      refresh_interval = 16'd0;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      fork
         main_seq();
         begin
            repeat (150000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + mon_chk, n_bad + mon_bad);
      $finish;
   end
endmodule